// File: doc/BRIEF.md
# Indexed Host Access Decoder

This block sits at the front of a NAND flash controller's host data/command window. The window has two 32-bit word ports. The index port is at byte offset 0x00 and the data port is at byte offset 0x10. A write to the index port stores an index word, which holds a routing mode, a target bank and a mode payload. After that, every data-port access is sent to one of four downstream targets, chosen by the stored mode. One index write serves any number of following data-port accesses, and each accepted access makes exactly one downstream request.

In direct-controller mode, the low two bits of the index word select the request type: a command cycle, an address cycle or a data cycle for the NAND bus engine. In PIO page mode, the payload holds the page number, and each data access moves one 32-bit word. Direct buffer access and the high-level control plane are forwarded the same way, as tagged requests. The host handshake is `host_req` with `host_ready`. An access completes in the cycle where both are high, and read data is valid in that same cycle.

Control is a two-state machine. `ST_UNSET` is entered at reset; in it no index has been written, and data accesses are absorbed without a downstream request. The transition `UNSET_TO_ARMED` fires on the first accepted index write. `ST_ARMED` then holds until reset, and each later index write replaces the stored word.

Top module: `host_index_decoder`

## Requirements
- R1: After reset the stored index word is zero (mode 00, bank 0), reading offset 0x00 returns 0, `idx_err` is 0 and `dn_valid` is all zero.
- R2: Before the first index write, a data-port access completes at once (`host_ready`=1), returns 0 and raises no `dn_valid` bit.
- R3: An accepted write at offset 0x00 stores the whole word, which a read at 0x00 returns from the next cycle on. No other access changes the stored word.
- R4: Index bits 27:26 pick the target. A data-port access raises only `dn_valid[mode]`, where 0 is the buffer, 1 is PIO page, 2 is the control plane and 3 is direct controller.
- R5: During a routed access, `dn_bank` carries index bits 25:24 and `dn_param` carries index bits 23:0. In mode 01 the latter is the page number.
- R6: In mode 11, `dn_cycle` carries index bits 1:0: 00 is a command, 01 an address and 10 data. Code 11 is reserved: such accesses complete at once, raise no request, return 0 and set `idx_err`, which stays set until reset.
- R7: A routed data access waits. `host_ready` equals `dn_ready[mode]`, so the host stalls until the selected target is ready.
- R8: Every data access reuses the stored index and makes one request. `dn_we` and `dn_wdata` mirror the host, and a read returns `dn_rdata`.
- R9: An access at any offset other than 0x00 or 0x10 completes at once, returns 0 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset within the window |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access completes this cycle |
| host_rdata | output | 32 | Read data |
| dn_valid | output | 4 | One request strobe per target, indexed by mode |
| dn_ready | input | 4 | Per-target ready |
| dn_we | output | 1 | Request direction |
| dn_wdata | output | 32 | Request write data |
| dn_rdata | input | 32 | Read data from the selected target |
| dn_bank | output | 2 | Target bank |
| dn_cycle | output | 2 | Direct-mode cycle type |
| dn_param | output | 24 | Mode payload (page number in PIO mode) |
| idx_err | output | 1 | Sticky reserved-cycle error |

## Verification
The bench compares every output with a behavioural model on every cycle. It targets the following corner cases:
- Data accesses made before any index write. A design that skipped the unset state would send requests to the buffer target.
- The reserved cycle code. A wrong design would forward it as a fourth cycle type, or would let a later valid index clear the error flag.
- Requests held while `dn_ready` is low. A wrong design would complete the access early, or would repeat it.
- Long runs of data accesses after one index write, plus accesses to unused offsets. A design that disturbed the stored word there would change the bank or page of later requests.

// File: rtl/hid_pkg.sv
package hid_pkg;
    typedef enum logic [1:0] {
        MD_BUF    = 2'b00,
        MD_PIO    = 2'b01,
        MD_CTRL   = 2'b10,
        MD_DIRECT = 2'b11
    } hid_mode_e;

    typedef enum logic [1:0] {
        CY_CMD  = 2'b00,
        CY_ADDR = 2'b01,
        CY_DATA = 2'b10,
        CY_RSVD = 2'b11
    } hid_cycle_e;

    typedef enum logic {
        ST_UNSET = 1'b0,
        ST_ARMED = 1'b1
    } hid_state_e;

    localparam int MODE_LSB = 26;
    localparam int BANK_LSB = 24;
endpackage

// File: rtl/hid_index_reg.sv
module hid_index_reg
    import hid_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [DATA_W-1:0] idx_wdata,
    input  logic              rsvd_hit,
    output logic [DATA_W-1:0] idx_q,
    output logic              armed,
    output logic              err_q
);
    hid_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_UNSET;
        else        state_q <= state_d;
    end

    // transitions: UNSET_TO_ARMED on first index write, ARMED holds
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNSET: if (idx_wr) state_d = ST_ARMED;
            ST_ARMED: state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (idx_wr)   idx_q <= idx_wdata;
            if (rsvd_hit) err_q <= 1'b1;
        end
    end

    assign armed = (state_q == ST_ARMED);

    a_r3_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_q));
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    a_r1_unset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (idx_q == '0));
endmodule

// File: rtl/hid_router.sv
module hid_router
    import hid_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int MODE_W   = 2,
    parameter int BANK_W   = 2,
    parameter int IDX_OFF  = 0,
    parameter int DATA_OFF = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_req,
    input  logic                    host_we,
    input  logic [ADDR_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]       host_wdata,
    output logic                    host_ready,
    output logic [DATA_W-1:0]       host_rdata,
    input  logic [DATA_W-1:0]       idx_q,
    input  logic                    armed,
    output logic [(1<<MODE_W)-1:0]  dn_valid,
    input  logic [(1<<MODE_W)-1:0]  dn_ready,
    output logic                    dn_we,
    output logic [DATA_W-1:0]       dn_wdata,
    input  logic [DATA_W-1:0]       dn_rdata,
    output logic [BANK_W-1:0]       dn_bank,
    output logic [1:0]              dn_cycle,
    output logic [BANK_LSB-1:0]     dn_param,
    output logic                    idx_wr,
    output logic                    rsvd_hit
);
    localparam int NT = 1 << MODE_W;

    logic              hit_idx, hit_data, reserved, routed;
    logic [MODE_W-1:0] mode;

    assign hit_idx  = (host_addr == ADDR_W'(IDX_OFF));
    assign hit_data = (host_addr == ADDR_W'(DATA_OFF));
    assign mode     = idx_q[MODE_LSB +: MODE_W];
    assign reserved = (mode == MODE_W'(MD_DIRECT)) && (idx_q[1:0] == CY_RSVD);
    assign routed   = hit_data && armed && !reserved;

    for (genvar t = 0; t < NT; t++) begin : g_target
        assign dn_valid[t] = host_req && routed && (mode == MODE_W'(t));
    end

    always_comb begin
        host_ready = routed ? dn_ready[mode] : 1'b1;
        if (hit_idx)     host_rdata = idx_q;
        else if (routed) host_rdata = dn_rdata;
        else             host_rdata = '0;
    end

    assign dn_we    = host_we;
    assign dn_wdata = host_wdata;
    assign dn_bank  = idx_q[BANK_LSB +: BANK_W];
    assign dn_cycle = idx_q[1:0];
    assign dn_param = idx_q[BANK_LSB-1:0];
    assign idx_wr   = host_req && host_we && hit_idx;
    assign rsvd_hit = host_req && hit_data && armed && reserved;

    a_r4_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_valid));
    a_r2_quiet_unset: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (dn_valid == '0));
    a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_valid) |-> (host_ready == |(dn_valid & dn_ready)));
endmodule

// File: rtl/host_index_decoder.sv
module host_index_decoder
    import hid_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int MODE_W = 2,
    parameter int BANK_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ready,
    output logic [DATA_W-1:0]      host_rdata,
    output logic [(1<<MODE_W)-1:0] dn_valid,
    input  logic [(1<<MODE_W)-1:0] dn_ready,
    output logic                   dn_we,
    output logic [DATA_W-1:0]      dn_wdata,
    input  logic [DATA_W-1:0]      dn_rdata,
    output logic [BANK_W-1:0]      dn_bank,
    output logic [1:0]             dn_cycle,
    output logic [BANK_LSB-1:0]    dn_param,
    output logic                   idx_err
);
    logic [DATA_W-1:0] idx_q;
    logic              armed, idx_wr, rsvd_hit;

    hid_index_reg #(.DATA_W(DATA_W)) u_index (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (host_wdata),
        .rsvd_hit  (rsvd_hit),
        .idx_q     (idx_q),
        .armed     (armed),
        .err_q     (idx_err)
    );

    hid_router #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .MODE_W (MODE_W),
        .BANK_W (BANK_W)
    ) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .idx_q      (idx_q),
        .armed      (armed),
        .dn_valid   (dn_valid),
        .dn_ready   (dn_ready),
        .dn_we      (dn_we),
        .dn_wdata   (dn_wdata),
        .dn_rdata   (dn_rdata),
        .dn_bank    (dn_bank),
        .dn_cycle   (dn_cycle),
        .dn_param   (dn_param),
        .idx_wr     (idx_wr),
        .rsvd_hit   (rsvd_hit)
    );
endmodule

// File: tb/host_index_decoder_test.sv
`timescale 1ns/1ps
module host_index_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, dn_rdata = '0;
    logic [3:0]  dn_ready = '0;
    logic        host_ready, dn_we, idx_err;
    logic [31:0] host_rdata, dn_wdata;
    logic [3:0]  dn_valid;
    logic [1:0]  dn_bank, dn_cycle;
    logic [23:0] dn_param;

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_idx = '0;
    bit          m_armed = 0, m_err = 0;

    host_index_decoder uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
        .dn_we(dn_we), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .dn_bank(dn_bank), .dn_cycle(dn_cycle), .dn_param(dn_param),
        .idx_err(idx_err)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit req, bit we, logic [4:0] addr,
                        logic [31:0] wd, logic [3:0] rdy, logic [31:0] rd);
        logic [1:0]  mode;
        bit          rsv, exp_ready;
        logic [31:0] exp_rdata;
        logic [3:0]  exp_valid;
        @(negedge clk);
        host_req = req; host_we = we; host_addr = addr;
        host_wdata = wd; dn_ready = rdy; dn_rdata = rd;
        #2;
        mode = m_idx[27:26];
        rsv = (mode == 2'b11) && (m_idx[1:0] == 2'b11);
        exp_valid = '0;
        if (addr == 5'h00) begin
            exp_ready = 1; exp_rdata = m_idx;
        end else if (addr == 5'h10 && m_armed && !rsv) begin
            exp_ready = rdy[mode]; exp_rdata = rd;
            if (req) exp_valid = 4'(1) << mode;
        end else begin
            exp_ready = 1; exp_rdata = '0;
        end
        chk(tag, "host_ready", 32'(host_ready), 32'(exp_ready));
        chk(tag, "host_rdata", host_rdata, exp_rdata);
        chk(tag, "dn_valid", 32'(dn_valid), 32'(exp_valid));
        chk(tag, "idx_err", 32'(idx_err), 32'(m_err));
        if (exp_valid != 0) begin
            chk(tag, "dn_we", 32'(dn_we), 32'(we));
            chk(tag, "dn_wdata", dn_wdata, wd);
            chk(tag, "dn_bank", 32'(dn_bank), 32'(m_idx[25:24]));
            chk(tag, "dn_param", 32'(dn_param), 32'(m_idx[23:0]));
            chk(tag, "dn_cycle", 32'(dn_cycle), 32'(m_idx[1:0]));
        end
        @(posedge clk);
        #1;
        if (req && exp_ready) begin
            if (addr == 5'h00 && we) begin m_idx = wd; m_armed = 1; end
            if (addr == 5'h10 && m_armed && rsv) m_err = 1;
        end
    endtask

    function automatic logic [31:0] ix(int md, int bank, int pay);
        return (32'(md) << 26) | (32'(bank) << 24) | 32'(pay);
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step("R1", 0, 0, 5'h00, 0, 4'hF, 32'h0);
        step("R1", 1, 0, 5'h00, 0, 4'hF, 32'h0);
        // R2 data access before any index write
        step("R2", 1, 1, 5'h10, 32'hAAAA5555, 4'h0, 32'h0);
        step("R2", 1, 0, 5'h10, 0, 4'h0, 32'hDEAD0001);
        // R3 index write and readback; R6 command cycle in bank 2
        step("R3", 1, 1, 5'h00, ix(3, 2, 0), 4'hF, 0);
        step("R3", 1, 0, 5'h00, 0, 4'hF, 0);
        // R8 stream of command cycles, R6 cycle code 00
        for (int i = 0; i < 4; i++)
            step("R8", 1, 1, 5'h10, 32'h70 + 32'(i), 4'hF, 0);
        // R7 stall while the direct target is not ready
        for (int i = 0; i < 3; i++)
            step("R7", 1, 1, 5'h10, 32'h90, 4'h7, 0);
        step("R7", 1, 1, 5'h10, 32'h90, 4'h8, 0);
        // R6 address cycle then data cycle read
        step("R6", 1, 1, 5'h00, ix(3, 1, 1), 4'hF, 0);
        step("R6", 1, 1, 5'h10, 32'h12, 4'hF, 0);
        step("R6", 1, 1, 5'h00, ix(3, 0, 2), 4'hF, 0);
        step("R8", 1, 0, 5'h10, 0, 4'hF, 32'hC0FFEE11);
        // R5 PIO page mode, page number in payload
        step("R5", 1, 1, 5'h00, ix(1, 1, 24'h01234), 4'hF, 0);
        for (int i = 0; i < 5; i++)
            step("R5", 1, 0, 5'h10, 0, 4'hF, 32'h1000 * 32'(i + 1));
        step("R7", 1, 0, 5'h10, 0, 4'hD, 32'h55);
        // R4 buffer and control-plane targets
        step("R4", 1, 1, 5'h00, ix(0, 3, 24'h00ABC), 4'hF, 0);
        step("R4", 1, 1, 5'h10, 32'h1, 4'hF, 0);
        step("R4", 1, 1, 5'h00, ix(2, 0, 24'h7FFFF), 4'hF, 0);
        step("R4", 1, 1, 5'h10, 32'h1, 4'hF, 0);
        step("R4", 0, 1, 5'h10, 32'h1, 4'hF, 0);
        // R9 unused offsets have no effect
        step("R9", 1, 1, 5'h08, 32'hFFFFFFFF, 4'hF, 0);
        step("R9", 1, 0, 5'h04, 0, 4'hF, 32'h77);
        step("R9", 1, 0, 5'h00, 0, 4'hF, 0);
        // R6 reserved cycle code: ignored, sticky error
        step("R6", 1, 1, 5'h00, ix(3, 2, 3), 4'h0, 0);
        step("R6", 1, 1, 5'h10, 32'h5, 4'h0, 32'h99);
        step("R6", 1, 0, 5'h10, 0, 4'h0, 32'h99);
        step("R6", 1, 1, 5'h00, ix(2, 1, 5), 4'hF, 0);
        step("R6", 1, 1, 5'h10, 32'h6, 4'hF, 0);
        // R3 data writes leave the index intact
        step("R3", 1, 0, 5'h00, 0, 4'hF, 0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule